// File: doc/BRIEF.md
# PHY Control-Port Access Sequencer

This block is a hardware master for the narrow register-access port of a serial-link PHY. It drives one 32-bit control word toward the PHY and watches one 32-bit status word that comes back. A client asks for a single register read or write: a 16-bit PHY register address plus, for a write, 16 bits of data. The sequencer then walks through the address-capture, data-capture and strobe phases of that port. It returns the read value with a one-cycle `done` pulse, or raises a one-cycle `err` pulse if the PHY stops acknowledging.

Every phase is a four-phase toggle of one control bit, acknowledged on one ack line. The bit is raised, the block waits for ack high, the bit is dropped, and the block waits for ack low. Each wait polls a bounded number of times, and the spacing of the polls comes from a programmable clock prescaler. A non-zero write to the PHY clock/reset register cannot be acknowledged, because the PHY is being reset. That write leaves the data and the write strobe on the port and finishes at once.

A start-up command resets the PHY and then polls the lane status register until its receive-PLL-locked bit appears. If the bit has not appeared after a bounded number of attempts, the command reports an error.

Top module: `phy_cport_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ctl_word` is zero and `busy`, `done` and `err` are low.
- R2: Fields of `ctl_word`: the value field is bits 15:0; the strobes are capture-address in bit 16, capture-data in bit 17, write in bit 18 and read in bit 19; bits 31:20 are zero. At most one strobe is set at a time. Fields of `stat_word`: ack is bit 18 and read data is bits 15:0.
- R3: A strobe is dropped only after ack has been seen high. The next strobe is raised only after ack has been seen low. A capture or read strobe that falls without a prior high ack is followed by `err`.
- R4: A wait polls ack once per prescaler tick, up to POLL_LIMIT times. If ack still has not arrived, the operation ends with `err` and all strobe bits are cleared.
- R5: A tick occurs every `cfg_div`+1 clock cycles. The settle delay, the gaps between lock polls and the ack polls are all counted in ticks.
- R6: A write first puts the address in the value field and waits SETTLE_TICKS ticks. It then toggles capture-address, then toggles capture-data with the write data in the value field, then toggles the write strobe. A later read of the same register returns the written value.
- R7: A write of non-zero data to register 0x7F3F (clock/reset) does not wait for ack on the write strobe. It finishes with `done`, and `ctl_word` is left holding the data with bit 18 set.
- R8: A write of zero to 0x7F3F uses the normal acknowledged path and leaves no strobe set.
- R9: A read does the address phase and then raises the read strobe. It latches `stat_word[15:0]` at the poll that sees ack high, and presents that value on `rd_data` when `done` pulses.
- R10: `init_start` writes 0x0001 to 0x7F3F. It then reads 0x2003, with GAP_TICKS ticks before each read, until bit 1 of the value is set, and finishes with `done`.
- R11: If the lock bit is still clear after LOCK_TRIES reads of 0x2003, the start-up routine ends with `err`.
- R12: `busy` rises on acceptance and falls in the cycle in which `done` or `err` pulses. Each of those pulses lasts one cycle. Requests made while `busy` is high are ignored.
- R13: When `init_start` and `req_valid` are both high while idle, the start-up routine runs and the single request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Prescaler: a tick every cfg_div+1 cycles |
| req_valid | input | 1 | Single-access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_data | input | 16 | Write data |
| init_start | input | 1 | Start the reset-and-lock routine |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle timeout pulse |
| rd_data | output | 16 | Last value read |
| ctl_word | output | 32 | Control word to the PHY |
| stat_word | input | 32 | Status word from the PHY |

## Verification
The bench builds the block with POLL_LIMIT=8, LOCK_TRIES=4, SETTLE_TICKS=2 and GAP_TICKS=2, and with an 8-bit prescaler. At these values, an ack that never arrives or never clears reaches the timeout within a few dozen cycles. A lock bit that never sets exhausts the start-up retries after four reads. Running the same timeout with `cfg_div` set to 0 and then to 3 shows that the wait grows with the prescaler. A behavioural PHY in the bench delays ack by two cycles, can withhold ack or hold it high, and never acknowledges the reset write.

// File: rtl/phy_cport_pkg.sv
package phy_cport_pkg;
  localparam logic [15:0] RST_REG  = 16'h7F3F;
  localparam logic [15:0] LOCK_REG = 16'h2003;
  localparam int          LOCK_BIT = 1;
  localparam int          ACK_BIT  = 18;

  // strobe index = bit position in ctl_word minus 16
  typedef enum logic [1:0] {
    SB_CAPA = 2'd0,
    SB_CAPD = 2'd1,
    SB_WR   = 2'd2,
    SB_RD   = 2'd3
  } strobe_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_CAPA, S_CAPD, S_WR, S_RD, S_END, S_GAP
  } seq_st_e;

  typedef enum logic [1:0] {
    H_IDLE, H_HI, H_LO
  } hs_st_e;
endpackage

// File: rtl/phy_cport_tick.sv
module phy_cport_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= cfg_div);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/phy_cport_hs.sv
module phy_cport_hs
  import phy_cport_pkg::*;
#(
  parameter int POLL_LIMIT = 5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        go,
  input  logic        hold,
  input  logic        flush,
  input  strobe_e     sel,
  input  logic        ack,
  input  logic [15:0] sdata,
  output logic [3:0]  strobe,
  output logic        fin,
  output logic        tmo,
  output logic [15:0] snap
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] PLAST = PW'(POLL_LIMIT - 1);

  hs_st_e        st;
  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= H_IDLE;
      strobe <= '0;
      fin    <= 1'b0;
      tmo    <= 1'b0;
      snap   <= '0;
      pcnt   <= '0;
    end else begin
      fin <= 1'b0;
      tmo <= 1'b0;
      if (flush) strobe <= '0;
      case (st)
        H_IDLE: if (go) begin
          strobe <= 4'b0001 << sel;
          pcnt   <= '0;
          if (hold) fin <= 1'b1;
          else      st  <= H_HI;
        end
        H_HI: if (tick) begin
          if (ack) begin
            strobe <= '0;
            snap   <= sdata;
            pcnt   <= '0;
            st     <= H_LO;
          end else if (pcnt == PLAST) begin
            strobe <= '0;
            tmo    <= 1'b1;
            st     <= H_IDLE;
          end else pcnt <= pcnt + 1'b1;
        end
        H_LO: if (tick) begin
          if (!ack) begin
            fin <= 1'b1;
            st  <= H_IDLE;
          end else if (pcnt == PLAST) begin
            tmo <= 1'b1;
            st  <= H_IDLE;
          end else pcnt <= pcnt + 1'b1;
        end
        default: st <= H_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_cport_fsm.sv
module phy_cport_fsm
  import phy_cport_pkg::*;
#(
  parameter int LOCK_TRIES   = 50,
  parameter int SETTLE_TICKS = 4,
  parameter int GAP_TICKS    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_data,
  input  logic        init_start,
  input  logic        fin,
  input  logic        tmo,
  input  logic [15:0] snap,
  output logic        go,
  output logic        hold,
  output logic        flush,
  output strobe_e     sel,
  output logic [15:0] field,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rd_data
);
  localparam int WW = $clog2(SETTLE_TICKS + GAP_TICKS + 1);
  localparam int TW = $clog2(LOCK_TRIES + 1);
  localparam logic [WW-1:0] SLAST = WW'(SETTLE_TICKS - 1);
  localparam logic [WW-1:0] GLAST = WW'(GAP_TICKS - 1);
  localparam logic [TW-1:0] TLAST = TW'(LOCK_TRIES - 1);

  seq_st_e       st;
  logic          op_wr, init_md, stage;
  logic [15:0]   op_addr, op_data;
  logic [WW-1:0] wcnt;
  logic [TW-1:0] tries;

  assign flush = !busy && (req_valid || init_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; op_wr <= 1'b0; init_md <= 1'b0; stage <= 1'b0;
      op_addr <= '0; op_data <= '0; wcnt <= '0; tries <= '0;
      go <= 1'b0; hold <= 1'b0; sel <= SB_CAPA; field <= '0;
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; rd_data <= '0;
    end else begin
      go   <= 1'b0;
      hold <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
      if (tmo) begin
        err  <= 1'b1;
        busy <= 1'b0;
        st   <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            wcnt <= '0;
            if (init_start) begin
              init_md <= 1'b1; stage <= 1'b0; op_wr <= 1'b1;
              op_addr <= RST_REG; op_data <= 16'h0001; field <= RST_REG;
              busy <= 1'b1; st <= S_SETTLE;
            end else if (req_valid) begin
              init_md <= 1'b0; op_wr <= req_write;
              op_addr <= req_addr; op_data <= req_data; field <= req_addr;
              busy <= 1'b1; st <= S_SETTLE;
            end
          end
          S_SETTLE: if (tick) begin
            if (wcnt == SLAST) begin
              go <= 1'b1; sel <= SB_CAPA; st <= S_CAPA;
            end else wcnt <= wcnt + 1'b1;
          end
          S_CAPA: if (fin) begin
            go <= 1'b1;
            if (op_wr) begin
              field <= op_data; sel <= SB_CAPD; st <= S_CAPD;
            end else begin
              sel <= SB_RD; st <= S_RD;
            end
          end
          S_CAPD: if (fin) begin
            go   <= 1'b1;
            sel  <= SB_WR;
            hold <= (op_addr == RST_REG) && (op_data != 16'h0000);
            st   <= S_WR;
          end
          S_WR: if (fin) st <= S_END;
          S_RD: if (fin) begin
            rd_data <= snap;
            st      <= S_END;
          end
          S_END: begin
            wcnt <= '0;
            if (init_md && !stage) begin
              stage <= 1'b1; tries <= '0; st <= S_GAP;
            end else if (init_md && !rd_data[LOCK_BIT]) begin
              if (tries == TLAST) begin
                err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
              end else begin
                tries <= tries + 1'b1; st <= S_GAP;
              end
            end else begin
              done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
            end
          end
          S_GAP: if (tick) begin
            if (wcnt == GLAST) begin
              op_wr <= 1'b0; op_addr <= LOCK_REG; field <= LOCK_REG;
              wcnt <= '0; st <= S_SETTLE;
            end else wcnt <= wcnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/phy_cport_seq.sv
module phy_cport_seq
  import phy_cport_pkg::*;
#(
  parameter int DIV_W        = 16,
  parameter int POLL_LIMIT   = 5000,
  parameter int LOCK_TRIES   = 50,
  parameter int SETTLE_TICKS = 4,
  parameter int GAP_TICKS    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [15:0]      req_data,
  input  logic             init_start,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [15:0]      rd_data,
  output logic [31:0]      ctl_word,
  input  logic [31:0]      stat_word
);
  logic        tick, go, hold, flush, fin, tmo;
  strobe_e     sel;
  logic [3:0]  strobe;
  logic [15:0] field, snap;
  logic        unused_stat;

  assign unused_stat = ^{stat_word[31:19], stat_word[17:16]};
  assign ctl_word    = {12'd0, strobe, field};

  phy_cport_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .tick(tick)
  );

  phy_cport_hs #(.POLL_LIMIT(POLL_LIMIT)) hs_i (
    .clk(clk), .rst(rst), .tick(tick), .go(go), .hold(hold), .flush(flush),
    .sel(sel), .ack(stat_word[ACK_BIT]), .sdata(stat_word[15:0]),
    .strobe(strobe), .fin(fin), .tmo(tmo), .snap(snap)
  );

  phy_cport_fsm #(
    .LOCK_TRIES(LOCK_TRIES), .SETTLE_TICKS(SETTLE_TICKS), .GAP_TICKS(GAP_TICKS)
  ) fsm_i (
    .clk(clk), .rst(rst), .tick(tick), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
    .init_start(init_start), .fin(fin), .tmo(tmo), .snap(snap),
    .go(go), .hold(hold), .flush(flush), .sel(sel), .field(field),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data)
  );
endmodule

// File: rtl/phy_cport_chk.sv
module phy_cport_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [31:0] ctl_word,
  input logic [31:0] stat_word
);
  // R2
  onehot_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl_word[19:16]));

  // R3
  capa_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctl_word[16]) && !$past(stat_word[18])) |=> err);

  // R3
  capd_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctl_word[17]) && !$past(stat_word[18])) |=> err);

  // R3
  rd_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctl_word[19]) && !$past(stat_word[18])) |=> err);

  // R4
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (ctl_word[19:16] == 4'd0));

  // R12
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !busy);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R12
  excl_end_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
endmodule

bind phy_cport_seq phy_cport_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .ctl_word(ctl_word), .stat_word(stat_word)
);

// File: tb/phy_cport_seq_tb_top.sv
module phy_cport_seq_tb_top;
  localparam int DIV_W = 8;
  localparam int LOCK_TRIES = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0] cfg_div = '0;
  logic req_valid = 1'b0, req_write = 1'b0, init_start = 1'b0;
  logic [15:0] req_addr = '0, req_data = '0;
  logic busy, done, err;
  logic [15:0] rd_data;
  logic [31:0] ctl_word, stat_word;

  always #10 clk = ~clk;

  phy_cport_seq #(
    .DIV_W(DIV_W), .POLL_LIMIT(8), .LOCK_TRIES(LOCK_TRIES),
    .SETTLE_TICKS(2), .GAP_TICKS(2)
  ) dut_i (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
    .init_start(init_start), .busy(busy), .done(done), .err(err),
    .rd_data(rd_data), .ctl_word(ctl_word), .stat_word(stat_word)
  );

  // ---- behavioural PHY: mode 0 = ack after delay, 1 = never ack, 2 = ack stuck high
  int mode = 0;
  int lock_after = 1000;
  logic [15:0] regs [0:255];
  logic [15:0] m_addr, m_data, rst_val;
  int rd2003;
  logic [3:0] prev_s;
  logic [7:0] hist;
  wire  [3:0] s = ctl_word[19:16];
  wire  target = (|s) && !(s[2] && m_addr == 16'h7F3F && m_data != 16'h0);
  wire  ack = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : hist[1];
  wire  [15:0] rd_val = (m_addr == 16'h2003) ?
                        ((rd2003 >= lock_after) ? 16'h0002 : 16'h0000) :
                        regs[m_addr[7:0]];
  assign stat_word = {13'd0, ack, 2'd0, rd_val};

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) regs[i] <= 16'h0;
      regs[8'h42] <= 16'h1234;
      m_addr <= '0; m_data <= '0; rst_val <= '0; rd2003 <= 0;
      prev_s <= '0; hist <= '0;
    end else begin
      prev_s <= s;
      hist   <= {hist[6:0], target};
      if (s[0] && !prev_s[0]) m_addr <= ctl_word[15:0];
      if (s[1] && !prev_s[1]) m_data <= ctl_word[15:0];
      if (s[2] && !prev_s[2]) begin
        regs[m_addr[7:0]] <= m_data;
        if (m_addr == 16'h7F3F && m_data != 16'h0) begin
          rst_val <= m_data;
          rd2003  <= 0;
        end
      end
      if (s[3] && !prev_s[3] && m_addr == 16'h2003) rd2003 <= rd2003 + 1;
    end
  end

  // ---- checking
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  typedef struct {
    bit          is_err;
    bit          cmp;
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // monitor: pops one expectation per completion
  always @(negedge clk) begin
    if (!rst && (done || err)) begin
      if (sb_q.size() == 0) chk(1'b0, "R12 unexpected completion", {30'd0, err, done}, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(err == e.is_err && done == !e.is_err, {e.tag, " outcome"},
            {30'd0, err, done}, {30'd0, e.is_err, !e.is_err});
        if (e.cmp && done) chk(rd_data == e.val, {e.tag, " data"}, {16'd0, rd_data}, {16'd0, e.val});
      end
    end
  end

  task automatic wait_end(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!(done || err));
  endtask

  task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input bit exp_err, input bit cmp, input logic [15:0] ev,
                       input string tag, output int cyc);
    exp_t e;
    e.is_err = exp_err; e.cmp = cmp; e.val = ev; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, {tag, " R12 busy"}, {31'd0, busy}, 32'd1);
    wait_end(cyc);
  endtask

  task automatic do_init(input bit exp_err, input string tag);
    exp_t e;
    int cyc;
    e.is_err = exp_err; e.cmp = 1'b0; e.val = '0; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    init_start = 1'b1;
    @(negedge clk);
    init_start = 1'b0;
    wait_end(cyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_up();
  end

  initial begin
    int cyc, c0, c3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctl_word == 32'd0 && !busy && !done && !err, "R1 during reset",
        {ctl_word[31:3], busy, done, err}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctl_word == 32'd0 && !busy && !done && !err, "R1 after reset",
        {ctl_word[31:3], busy, done, err}, 32'd0);

    // R6 / R9 write then read back; R2 field positions seen by the PHY
    do_op(1'b1, 16'h0011, 16'hA5A5, 1'b0, 1'b0, '0, "R6 write", cyc);
    chk(ctl_word[31:16] == 16'd0, "R3 strobes idle after write", ctl_word, {16'd0, ctl_word[15:0]});
    chk(regs[8'h11] == 16'hA5A5, "R2 data field captured", {16'd0, regs[8'h11]}, 32'h0000A5A5);
    do_op(1'b0, 16'h0011, '0, 1'b0, 1'b1, 16'hA5A5, "R6 readback", cyc);
    do_op(1'b0, 16'h0042, '0, 1'b0, 1'b1, 16'h1234, "R9 read", cyc);
    chk(m_addr == 16'h0042, "R2 address field captured", {16'd0, m_addr}, 32'h42);

    // R12 request during busy is ignored
    begin
      exp_t e;
      e.is_err = 1'b0; e.cmp = 1'b0; e.val = '0; e.tag = "R12 first";
      sb_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0022; req_data = 16'hBEEF;
      @(negedge clk);
      req_addr = 16'h0033; req_data = 16'h7777;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_end(cyc);
    end
    do_op(1'b0, 16'h0033, '0, 1'b0, 1'b1, 16'h0000, "R12 ignored request", cyc);
    do_op(1'b0, 16'h0022, '0, 1'b0, 1'b1, 16'hBEEF, "R12 accepted request", cyc);

    // R7 reset-register bypass (the PHY never acks it)
    do_op(1'b1, 16'h7F3F, 16'h0001, 1'b0, 1'b0, '0, "R7 bypass", cyc);
    chk(ctl_word == 32'h0004_0001, "R7 held strobe", ctl_word, 32'h0004_0001);
    chk(rst_val == 16'h0001, "R7 reset value", {16'd0, rst_val}, 32'd1);
    // R8 zero write takes the acknowledged path
    do_op(1'b1, 16'h7F3F, 16'h0000, 1'b0, 1'b0, '0, "R8 zero write", cyc);
    chk(ctl_word[19:16] == 4'd0, "R8 no strobe left", ctl_word, 32'd0);

    // R4 timeouts: ack withheld, then ack stuck high
    mode = 1;
    do_op(1'b0, 16'h0011, '0, 1'b1, 1'b0, '0, "R4 no ack", c0);
    chk(ctl_word[19:16] == 4'd0, "R4 strobes cleared", ctl_word, 32'd0);
    chk(c0 >= 8, "R4 poll count", c0, 32'd8);
    mode = 2;
    do_op(1'b1, 16'h0011, 16'h5555, 1'b1, 1'b0, '0, "R4 stuck ack", cyc);
    chk(ctl_word[19:16] == 4'd0, "R4 strobes cleared stuck", ctl_word, 32'd0);
    mode = 0;
    repeat (4) @(negedge clk);

    // R5 prescaler stretches the same timeout
    cfg_div = 8'd3;
    mode = 1;
    do_op(1'b0, 16'h0011, '0, 1'b1, 1'b0, '0, "R5 slow timeout", c3);
    chk(c3 > 2 * c0, "R5 scaled wait", c3, 2 * c0);
    mode = 0;
    repeat (4) @(negedge clk);
    do_op(1'b0, 16'h0011, '0, 1'b0, 1'b1, 16'hA5A5, "R5 slow read", cyc);
    cfg_div = 8'd0;

    // R10 start-up with lock on the third poll
    lock_after = 3;
    do_init(1'b0, "R10 init");
    chk(rd2003 == 3, "R10 lock reads", rd2003, 32'd3);
    chk(rst_val == 16'h0001, "R10 reset written", {16'd0, rst_val}, 32'd1);
    chk(rd_data[1] == 1'b1, "R10 lock bit", {16'd0, rd_data}, 32'd2);

    // R11 lock never arrives
    lock_after = 1000;
    do_init(1'b1, "R11 init timeout");
    chk(rd2003 == LOCK_TRIES, "R11 lock reads", rd2003, LOCK_TRIES);

    // R13 init wins over a simultaneous request
    lock_after = 1;
    begin
      exp_t e;
      e.is_err = 1'b0; e.cmp = 1'b0; e.val = '0; e.tag = "R13 init";
      sb_q.push_back(e);
      @(negedge clk);
      init_start = 1'b1; req_valid = 1'b1; req_write = 1'b1;
      req_addr = 16'h0055; req_data = 16'h9999;
      @(negedge clk);
      init_start = 1'b0; req_valid = 1'b0;
      wait_end(cyc);
    end
    chk(rd2003 == 1, "R13 init ran", rd2003, 32'd1);
    do_op(1'b0, 16'h0055, '0, 1'b0, 1'b1, 16'h0000, "R13 request dropped", cyc);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R12 all completions seen", sb_q.size(), 32'd0);
    finish_up();
  end
endmodule